// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block is the 64-bit control and status word of a floating-point unit. It keeps a two-bit dynamic rounding-mode field that software sets, six sticky exception flags that the arithmetic datapath raises, and a summary bit that is the live OR of those flags. Software reads and writes the word through a plain register port. The datapath reports exceptions through a six-bit vector that it may drive in any cycle. All other bit positions are reserved.

The block also tells the issuing instruction which rounding mode to use. A static qualifier selects nearest, chopped or toward minus infinity directly. The dynamic qualifier selects the mode held in the stored field. Rounding toward plus infinity is available only through the dynamic field.

Top module: `fpcsr_top`

## Requirements
- R1: After reset, every bit of `csr_rdata` is 0. The dynamic field is therefore 00 (chopped), and a dynamic qualifier resolves to 00.
- R2: Bits 62..60 and 51..0 of `csr_rdata` always read 0. Writing ones to them has no visible effect.
- R3: Bits 59..58 hold the dynamic mode with the encoding 00 chopped, 01 toward minus infinity, 10 nearest, 11 toward plus infinity. A write loads the field, and the new value is readable from the cycle after the write. The field does not change while no write is made.
- R4: The exception flags are sticky. Bit i of `exc_set` sets the stored flag i at the next clock edge. A cycle with no write never clears a flag.
- R5: A software write replaces all six flags with `csr_wdata[57:52]`, and can clear flags that are set.
- R6: When a write and a report occur in the same cycle, the stored flags become `csr_wdata[57:52] | exc_set`.
- R7: Bit 63 always equals the OR of bits 57..52 of the stored word. The value written to bit 63 is ignored.
- R8: The static qualifiers resolve on `rmode_eff` as follows: `insn_qual` 00 gives 10 (nearest), 01 gives 00 (chopped) and 10 gives 01 (toward minus infinity).
- R9: `insn_qual` 11 (dynamic) makes `rmode_eff` equal to the stored bits 59..58. No static qualifier ever yields 11 (toward plus infinity).
- R10: Flag positions: `exc_set` bit 0 invalid operation lands in bit 52, bit 1 divide by zero in 53, bit 2 overflow in 54, bit 3 underflow in 55, bit 4 inexact in 56 and bit 5 integer overflow in 57.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Software write strobe |
| csr_wdata | input | 64 | Software write data |
| csr_rdata | output | 64 | Current register contents |
| exc_set | input | 6 | Exception report from the datapath, one bit per flag |
| insn_qual | input | 2 | Rounding qualifier of the issuing instruction |
| rmode_eff | output | 2 | Resolved rounding mode |

## Verification
The hardest case to reach is a software write that collides with a datapath report in the same cycle. The merge order decides whether an event is lost. The stimulus drives a write that clears all flags together with a single report bit, and then a write that sets other flags together with a different report. In both cases the result must be the union of the written flags and the reported flag. Plus-infinity rounding is reached only by first writing 11 into the dynamic field and then issuing the dynamic qualifier. The static qualifiers are then replayed with that field still set, to confirm that none of them yields 11.

// File: rtl/fpcsr_pkg.sv
// Package: shared bit positions, widths and encodings of the FP control/status word.
// Assumes a 64-bit word; the positions are fixed because software and the datapath decode them.
package fpcsr_pkg;
    localparam int CSR_W    = 64;
    localparam int NFLAGS   = 6;
    localparam int FLAG_LO  = 52;
    localparam int FLAG_HI  = FLAG_LO + NFLAGS - 1;
    localparam int DYN_LO   = 58;
    localparam int DYN_W    = 2;
    localparam int DYN_HI   = DYN_LO + DYN_W - 1;
    localparam int SUM_BIT  = 63;

    // Rounding mode encoding, identical to the stored dynamic field.
    typedef enum logic [1:0] {
        RM_CHOP    = 2'b00,
        RM_MINUS   = 2'b01,
        RM_NEAREST = 2'b10,
        RM_PLUS    = 2'b11
    } rmode_e;

    // Rounding qualifier carried by an instruction.
    typedef enum logic [1:0] {
        QL_NONE  = 2'b00,
        QL_CHOP  = 2'b01,
        QL_MINUS = 2'b10,
        QL_DYN   = 2'b11
    } qual_e;
endpackage

// File: rtl/fpcsr_flags.sv
// Module: sticky exception flag store with summary.
// Assumes: the write data is taken first in a cycle, and the report is ORed over it.
// A report never clears a flag; only a write does.
module fpcsr_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_flags,
    input  logic [N-1:0] report,
    output logic [N-1:0] flags,
    output logic         any_flag
);
    logic [N-1:0] flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        // Per-flag sticky register: base is write data or held value, report ORed on top.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[i] <= 1'b0;
            else if (wr_en)
                flag_q[i] <= wr_flags[i] | report[i];
            else
                flag_q[i] <= flag_q[i] | report[i];
        end
    end

    // Summary taken from stored flags only.
    always_comb begin
        any_flag = |flag_q;
    end

    assign flags = flag_q;
endmodule

// File: rtl/fpcsr_dyn.sv
// Module: dynamic rounding-mode field storage.
// Assumes: the field loads only on a software write and resets to chopped (all zeros).
module fpcsr_dyn #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] dyn
);
    logic [W-1:0] dyn_q;

    // Hold the field; a software write replaces it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dyn_q <= '0;
        else if (wr_en)
            dyn_q <= wr_val;
    end

    assign dyn = dyn_q;
endmodule

// File: rtl/fpcsr_resolve.sv
// Module: resolves the effective rounding mode for one instruction.
// Assumes: static qualifiers cover nearest, chopped and minus infinity, and the
// dynamic qualifier selects the stored field (the only way to reach plus infinity).
module fpcsr_resolve
    import fpcsr_pkg::*;
(
    input  logic [1:0] qual,
    input  logic [1:0] dyn,
    output logic [1:0] rmode
);
    // Map the qualifier to a rounding mode.
    always_comb begin
        unique case (qual_e'(qual))
            QL_NONE:  rmode = RM_NEAREST;
            QL_CHOP:  rmode = RM_CHOP;
            QL_MINUS: rmode = RM_MINUS;
            QL_DYN:   rmode = dyn;
            default:  rmode = RM_NEAREST;
        endcase
    end
endmodule

// File: rtl/fpcsr_top.sv
// Module: FP control/status register top. It stores the dynamic mode and the sticky flags,
// presents the 64-bit word with the live summary bit and reserved bits forced to zero,
// and resolves the rounding mode for the issuing instruction.
// Assumes: a synchronous active-low reset, and a read port that shows the state after the last edge.
module fpcsr_top
    import fpcsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  csr_rdata,
    input  logic [NFLAGS-1:0] exc_set,
    input  logic [1:0]        insn_qual,
    output logic [1:0]        rmode_eff
);
    logic [NFLAGS-1:0] flags;
    logic              summary;
    logic [DYN_W-1:0]  dyn;

    fpcsr_flags #(.N(NFLAGS)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (csr_we),
        .wr_flags (csr_wdata[FLAG_HI:FLAG_LO]),
        .report   (exc_set),
        .flags    (flags),
        .any_flag (summary)
    );

    fpcsr_dyn #(.W(DYN_W)) u_dyn (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (csr_we),
        .wr_val (csr_wdata[DYN_HI:DYN_LO]),
        .dyn    (dyn)
    );

    fpcsr_resolve u_res (
        .qual  (insn_qual),
        .dyn   (dyn),
        .rmode (rmode_eff)
    );

    // Assemble the readable word; every bit not placed here reads zero.
    always_comb begin
        csr_rdata                  = '0;
        csr_rdata[SUM_BIT]         = summary;
        csr_rdata[DYN_HI:DYN_LO]   = dyn;
        csr_rdata[FLAG_HI:FLAG_LO] = flags;
    end
endmodule

// File: rtl/fpcsr_checker.sv
// Checker: temporal properties of the control/status register, observed at its ports.
module fpcsr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_we,
    input logic [63:0] csr_wdata,
    input logic [63:0] csr_rdata,
    input logic [5:0]  exc_set,
    input logic [1:0]  insn_qual,
    input logic [1:0]  rmode_eff
);
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[62:60] == 3'b0) && (csr_rdata[51:0] == 52'b0)); // R2

    AST_SUMMARY_OR: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[63] == (|csr_rdata[57:52])); // R7

    AST_DYN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we |=> $stable(csr_rdata[59:58])); // R3

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we |=> ((csr_rdata[57:52] & $past(csr_rdata[57:52])) == $past(csr_rdata[57:52]))); // R4

    AST_REPORT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (|exc_set) |=> ((csr_rdata[57:52] & $past(exc_set)) == $past(exc_set))); // R4

    AST_WRITE_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |=> (csr_rdata[57:52] == ($past(csr_wdata[57:52]) | $past(exc_set)))); // R6

    AST_NO_STATIC_PLUS: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_qual != 2'b11) |-> (rmode_eff != 2'b11)); // R9

    AST_DYN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_qual == 2'b11) |-> (rmode_eff == csr_rdata[59:58])); // R9
endmodule

bind fpcsr_top fpcsr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .exc_set   (exc_set),
    .insn_qual (insn_qual),
    .rmode_eff (rmode_eff)
);

// File: tb/fpcsr_top_bench.sv
// Bench: a driver task applies one operation per cycle and pushes the expected word and mode.
// A monitor pops and compares them after each rising edge.
module fpcsr_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic [5:0]  exc_set = '0;
    logic [1:0]  insn_qual = 2'b00;
    logic [1:0]  rmode_eff;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Reference model state
    logic [5:0] m_flags = '0;
    logic [1:0] m_dyn = '0;

    logic [63:0] q_word[$];
    logic [1:0]  q_mode[$];
    string       q_tag[$];

    fpcsr_top u_fpcsr_top (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .exc_set(exc_set), .insn_qual(insn_qual),
        .rmode_eff(rmode_eff)
    );

    always #5 clk = ~clk;

    function automatic logic [63:0] exp_word(logic [5:0] f, logic [1:0] d);
        logic [63:0] w;
        w = '0;
        w[63] = |f;
        w[59:58] = d;
        w[57:52] = f;
        return w;
    endfunction

    function automatic logic [1:0] exp_mode(logic [1:0] q, logic [1:0] d);
        case (q)
            2'b00: return 2'b10;
            2'b01: return 2'b00;
            2'b10: return 2'b01;
            default: return d;
        endcase
    endfunction

    // Driver: apply one cycle of stimulus and record the expected outcome.
    task automatic op(input bit we, input logic [63:0] wd, input logic [5:0] ex,
                      input logic [1:0] q, input string tag);
        @(negedge clk);
        csr_we = we;
        csr_wdata = wd;
        exc_set = ex;
        insn_qual = q;
        if (we) begin
            m_flags = wd[57:52] | ex;
            m_dyn = wd[59:58];
        end else begin
            m_flags = m_flags | ex;
        end
        q_word.push_back(exp_word(m_flags, m_dyn));
        q_mode.push_back(exp_mode(q, m_dyn));
        q_tag.push_back(tag);
    endtask

    // Monitor: after each edge, compare the expectation pushed before it.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_word.size() > 0) begin
                logic [63:0] ew;
                logic [1:0]  em;
                string       t;
                ew = q_word.pop_front();
                em = q_mode.pop_front();
                t  = q_tag.pop_front();
                total++;
                if (csr_rdata !== ew) begin
                    bad++;
                    $display("FAIL %s word: got %h expected %h", t, csr_rdata, ew);
                end
                total++;
                if (rmode_eff !== em) begin
                    bad++;
                    $display("FAIL %s mode: got %b expected %b", t, rmode_eff, em);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        insn_qual = 2'b11;
        repeat (3) @(posedge clk);
        #2;
        total++; // R1 word reads zero while held in reset
        if (csr_rdata !== 64'h0) begin
            bad++;
            $display("FAIL R1 reset word: got %h expected %h", csr_rdata, 64'h0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        op(0, '0, '0, 2'b11, "R1");                    // dynamic resolves to chopped
        op(0, '0, '0, 2'b00, "R8 none");
        op(0, '0, '0, 2'b01, "R8 chop");
        op(0, '0, '0, 2'b10, "R8 minus");
        for (int d = 0; d < 4; d++) begin
            logic [63:0] w;
            w = '0;
            w[59:58] = 2'(d);
            op(1, w, '0, 2'b11, "R3 R9 dyn write");
        end
        op(0, '0, '0, 2'b00, "R9 static not plus");
        op(0, '0, '0, 2'b01, "R9 static not plus");
        op(0, '0, '0, 2'b10, "R9 static not plus");
        op(0, '0, '0, 2'b11, "R3 hold");
        op(1, {64{1'b1}}, '0, 2'b11, "R2 all ones");
        op(1, 64'h8000_0000_0000_0000, '0, 2'b11, "R7 sum write ignored");
        op(1, 64'h7000_0000_000F_FFFF, '0, 2'b11, "R2 reserved ignored");
        for (int i = 0; i < 6; i++)
            op(0, '0, 6'(1 << i), 2'b00, "R10 R4 flag position");
        op(0, '0, '0, 2'b00, "R4 sticky idle");
        op(0, '0, 6'b000001, 2'b00, "R4 repeat report");
        op(1, 64'h0400_0000_0000_0000, '0, 2'b01, "R5 write clears");
        op(1, '0, '0, 2'b01, "R5 R7 all clear");
        op(1, '0, 6'b000100, 2'b10, "R6 clear with report");
        op(1, 64'h0090_0000_0000_0000, 6'b100000, 2'b10, "R6 set with report");
        op(0, '0, '0, 2'b11, "R6 R4 idle after merge");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule